// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block fetches outgoing frames for a network controller from a chain of descriptors kept in host memory. Software fills a descriptor, hands it to the controller by setting the ownership flag in its status word, and then kicks the block. The walker reads the descriptor at the current transmit pointer and sends the frame bytes it points to on a byte stream. It returns the descriptor to the host by clearing the ownership flag in memory, follows the next-descriptor link, and counts the frame. It repeats this until it meets a descriptor the host still owns.

Each descriptor is six 16-bit words at consecutive even byte addresses: status at offset 0, byte length at offset 2, buffer address low and high halves at offsets 4 and 6, next-descriptor address low and high halves at offsets 8 and 10. Memory is reached through a 16-bit request/acknowledge port. A small register window holds the two kick sources, the transmit pointer halves, the frame counter and the interrupt status. Register offsets are: 0 control, 1 transmit command, 2 pointer low, 3 pointer high, 4 frame counter, 5 interrupt status.

Top module: `txdesc_walker`

## Requirements
- R1: After reset every register reads zero, `tx_irq` is low, and neither `mem_req` nor `out_valid` is asserted.
- R2: A write to the transmit command register with bit 0 set starts a walk; that register reads back with bit 0 zero and its other bits as written.
- R3: A write to the control register that takes bit 12 from 0 to 1 starts a walk; a write that leaves bit 12 at 1 starts none.
- R4: A descriptor is sent only when bit 15 of its status word is 1, and the walk ends at the first descriptor with bit 15 at 0. Frame bytes come from the buffer address in ascending order, low byte of each memory word first, with `out_last` high on the final byte only.
- R5: The number of bytes sent is the descriptor length, capped at `MAX_LEN` (2000 by default); a zero length sends no bytes but the descriptor is still completed.
- R6: After a frame, the status word is written back with bit 15 cleared and its other bits unchanged, and the transmit pointer takes the next-descriptor address, visible in the pointer registers.
- R7: The frame counter rises by one per completed descriptor, clears when read, and ignores writes.
- R8: At the end of a walk that completed at least one descriptor, interrupt status bit 4 and `tx_irq` go high; a walk that completes none leaves them low. Reading the interrupt status clears it.
- R9: A kick that arrives while a walk is running causes one further walk from the current pointer after the running one ends.
- R10: `out_data` and `out_last` hold while `out_valid` is high and `out_ready` is low, and a memory request holds its address and direction until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (applies read-to-clear side effects) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| tx_irq | output | 1 | Transmit-done interrupt (interrupt status bit 4) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid this cycle |
| mem_rdata | input | 16 | Read data |
| out_valid | output | 1 | Frame byte valid |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of a frame |
| out_ready | input | 1 | Sink accepts the byte |

## Verification
A single odd-length frame started by the command register shows byte order, the end marker on a half-used word and the status write-back. A three-frame chain started by the control bit, with a slow memory and a stalling sink, separates back-to-back draining from one-frame-per-kick behaviour and shows holding under backpressure. A ring whose first descriptor is host-owned, a repeated control write with bit 12 already high, an over-long frame followed by a zero-length one, and a second kick landing mid-frame (with the next descriptor handed over only after the first walk has looked at it) distinguish the stop rule, edge detection, the cap and the extra pass.

// File: rtl/txw_pkg.sv
package txw_pkg;

    localparam int PTR_W        = 32;
    localparam int WORD_W       = 16;
    localparam int OWN_BIT      = 15;
    localparam int DONE_BIT     = 4;
    localparam int CTL_KICK_BIT = 12;
    localparam int CMD_KICK_BIT = 0;

    typedef enum logic [2:0] {
        RA_CTL = 3'd0,
        RA_CMD = 3'd1,
        RA_PLO = 3'd2,
        RA_PHI = 3'd3,
        RA_CNT = 3'd4,
        RA_ISR = 3'd5
    } reg_addr_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_ST,
        S_RD_LEN,
        S_RD_BP0,
        S_RD_BP1,
        S_RD_NX0,
        S_RD_NX1,
        S_FETCH,
        S_EMIT0,
        S_EMIT1,
        S_WB,
        S_FIN
    } walk_state_e;

    // Byte offset of each descriptor field relative to the descriptor base.
    function automatic logic [3:0] desc_offset(walk_state_e st);
        case (st)
            S_RD_LEN: return 4'd2;
            S_RD_BP0: return 4'd4;
            S_RD_BP1: return 4'd6;
            S_RD_NX0: return 4'd8;
            S_RD_NX1: return 4'd10;
            default:  return 4'd0;
        endcase
    endfunction

    function automatic logic is_mem_state(walk_state_e st);
        return (st inside {S_RD_ST, S_RD_LEN, S_RD_BP0, S_RD_BP1,
                           S_RD_NX0, S_RD_NX1, S_FETCH, S_WB});
    endfunction

endpackage

// File: rtl/txw_regs.sv
module txw_regs
    import txw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [2:0]          reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    input  logic                ptr_load,
    input  logic [PTR_W-1:0]    ptr_next,
    input  logic                pkt_inc,
    input  logic                done_set,
    output logic [PTR_W-1:0]    tx_ptr,
    output logic                kick,
    output logic                tx_irq
);

    logic [WORD_W-1:0] ctl_q, cmd_q, isr_q, isr_nxt;
    logic [CNT_W-1:0]  cnt_q;
    logic [PTR_W-1:0]  ptr_q;

    logic wr_ctl, wr_cmd, wr_plo, wr_phi, rd_cnt, rd_isr;
    assign wr_ctl = reg_wr && (reg_addr == RA_CTL);
    assign wr_cmd = reg_wr && (reg_addr == RA_CMD);
    assign wr_plo = reg_wr && (reg_addr == RA_PLO);
    assign wr_phi = reg_wr && (reg_addr == RA_PHI);
    assign rd_cnt = reg_rd && (reg_addr == RA_CNT);
    assign rd_isr = reg_rd && (reg_addr == RA_ISR);

    assign kick = (wr_cmd && reg_wdata[CMD_KICK_BIT])
               || (wr_ctl && reg_wdata[CTL_KICK_BIT] && !ctl_q[CTL_KICK_BIT]);

    always_comb begin
        isr_nxt = rd_isr ? '0 : isr_q;
        if (done_set) isr_nxt[DONE_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            cmd_q <= '0;
            isr_q <= '0;
            cnt_q <= '0;
            ptr_q <= '0;
        end else begin
            if (wr_ctl) ctl_q <= reg_wdata;
            if (wr_cmd) cmd_q <= reg_wdata & ~(WORD_W'(1) << CMD_KICK_BIT);
            if (ptr_load) begin
                ptr_q <= ptr_next;
            end else begin
                if (wr_plo) ptr_q[WORD_W-1:0]     <= reg_wdata;
                if (wr_phi) ptr_q[PTR_W-1:WORD_W] <= reg_wdata;
            end
            if (pkt_inc)     cnt_q <= rd_cnt ? CNT_W'(1) : cnt_q + CNT_W'(1);
            else if (rd_cnt) cnt_q <= '0;
            isr_q <= isr_nxt;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTL:  reg_rdata = ctl_q;
            RA_CMD:  reg_rdata = cmd_q;
            RA_PLO:  reg_rdata = ptr_q[WORD_W-1:0];
            RA_PHI:  reg_rdata = ptr_q[PTR_W-1:WORD_W];
            RA_CNT:  reg_rdata = WORD_W'(cnt_q);
            RA_ISR:  reg_rdata = isr_q;
            default: reg_rdata = '0;
        endcase
    end

    assign tx_ptr = ptr_q;
    assign tx_irq = isr_q[DONE_BIT];

    // R7: a completed frame without a same-cycle read steps the counter by one
    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
        (pkt_inc && !rd_cnt) |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));

    // R8: end of a productive walk raises the interrupt
    a_r8_irq_set: assert property (@(posedge clk) disable iff (rst)
        done_set |=> tx_irq);

    // R6: the pointer follows the next-descriptor link
    a_r6_ptr_follow: assert property (@(posedge clk) disable iff (rst)
        ptr_load |=> tx_ptr == $past(ptr_next));

endmodule

// File: rtl/txw_walker.sv
module txw_walker
    import txw_pkg::*;
#(
    parameter int MAX_LEN = 2000,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               kick,
    input  logic [PTR_W-1:0]   tx_ptr,
    output logic               mem_req,
    output logic               mem_we,
    output logic [PTR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               out_valid,
    output logic [7:0]         out_data,
    output logic               out_last,
    input  logic               out_ready,
    output logic               ptr_load,
    output logic [PTR_W-1:0]   ptr_next,
    output logic               pkt_inc,
    output logic               done_set
);

    walk_state_e        state;
    logic [WORD_W-1:0]  status_q, word_q;
    logic [PTR_W-1:0]   bufp_q, nextp_q;
    logic [LEN_W-1:0]   rem_q, capped;
    logic               sent_q, pend_q;

    assign capped = (mem_rdata > WORD_W'(MAX_LEN)) ? LEN_W'(MAX_LEN)
                                                    : mem_rdata[LEN_W-1:0];

    assign mem_req   = is_mem_state(state);
    assign mem_we    = (state == S_WB);
    assign mem_addr  = (state == S_FETCH) ? bufp_q
                                          : tx_ptr + PTR_W'(desc_offset(state));
    assign mem_wdata = status_q & ~(WORD_W'(1) << OWN_BIT);

    assign out_valid = (state == S_EMIT0) || (state == S_EMIT1);
    assign out_data  = (state == S_EMIT1) ? word_q[15:8] : word_q[7:0];
    assign out_last  = (rem_q == LEN_W'(1));

    assign ptr_load  = (state == S_WB) && mem_ack;
    assign ptr_next  = nextp_q;
    assign pkt_inc   = ptr_load;
    assign done_set  = (state == S_FIN) && sent_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            status_q <= '0;
            word_q   <= '0;
            bufp_q   <= '0;
            nextp_q  <= '0;
            rem_q    <= '0;
            sent_q   <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (kick && state != S_IDLE && state != S_FIN) pend_q <= 1'b1;
            case (state)
                S_IDLE: if (kick) state <= S_RD_ST;
                S_RD_ST: if (mem_ack) begin
                    if (mem_rdata[OWN_BIT]) begin
                        status_q <= mem_rdata;
                        state    <= S_RD_LEN;
                    end else begin
                        state    <= S_FIN;
                    end
                end
                S_RD_LEN: if (mem_ack) begin
                    rem_q <= capped;
                    state <= S_RD_BP0;
                end
                S_RD_BP0: if (mem_ack) begin
                    bufp_q[WORD_W-1:0] <= mem_rdata;
                    state <= S_RD_BP1;
                end
                S_RD_BP1: if (mem_ack) begin
                    bufp_q[PTR_W-1:WORD_W] <= mem_rdata;
                    state <= S_RD_NX0;
                end
                S_RD_NX0: if (mem_ack) begin
                    nextp_q[WORD_W-1:0] <= mem_rdata;
                    state <= S_RD_NX1;
                end
                S_RD_NX1: if (mem_ack) begin
                    nextp_q[PTR_W-1:WORD_W] <= mem_rdata;
                    state <= (rem_q == '0) ? S_WB : S_FETCH;
                end
                S_FETCH: if (mem_ack) begin
                    word_q <= mem_rdata;
                    bufp_q <= bufp_q + PTR_W'(2);
                    state  <= S_EMIT0;
                end
                S_EMIT0: if (out_ready) begin
                    rem_q <= rem_q - LEN_W'(1);
                    state <= (rem_q == LEN_W'(1)) ? S_WB : S_EMIT1;
                end
                S_EMIT1: if (out_ready) begin
                    rem_q <= rem_q - LEN_W'(1);
                    state <= (rem_q == LEN_W'(1)) ? S_WB : S_FETCH;
                end
                S_WB: if (mem_ack) begin
                    sent_q <= 1'b1;
                    state  <= S_RD_ST;
                end
                S_FIN: begin
                    sent_q <= 1'b0;
                    pend_q <= 1'b0;
                    state  <= (pend_q || kick) ? S_RD_ST : S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R10: stream byte held under backpressure
    a_r10_stream_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));

    // R10: memory request held until acknowledged
    a_r10_mem_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R5: remaining byte count never exceeds the cap
    a_r5_len_bound: assert property (@(posedge clk) disable iff (rst)
        rem_q <= LEN_W'(MAX_LEN));

    // R4: a host-owned status word ends the walk without streaming
    a_r4_stop_unowned: assert property (@(posedge clk) disable iff (rst)
        (state == S_RD_ST && mem_ack && !mem_rdata[OWN_BIT]) |=> !out_valid && !mem_req);

endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
    import txw_pkg::*;
#(
    parameter int MAX_LEN = 2000,
    parameter int CNT_W   = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reg_wr,
    input  logic         reg_rd,
    input  logic [2:0]   reg_addr,
    input  logic [15:0]  reg_wdata,
    output logic [15:0]  reg_rdata,
    output logic         tx_irq,
    output logic         mem_req,
    output logic         mem_we,
    output logic [31:0]  mem_addr,
    output logic [15:0]  mem_wdata,
    input  logic         mem_ack,
    input  logic [15:0]  mem_rdata,
    output logic         out_valid,
    output logic [7:0]   out_data,
    output logic         out_last,
    input  logic         out_ready
);

    logic              kick, ptr_load, pkt_inc, done_set;
    logic [PTR_W-1:0]  tx_ptr, ptr_next;

    txw_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ptr_load  (ptr_load),
        .ptr_next  (ptr_next),
        .pkt_inc   (pkt_inc),
        .done_set  (done_set),
        .tx_ptr    (tx_ptr),
        .kick      (kick),
        .tx_irq    (tx_irq)
    );

    txw_walker #(.MAX_LEN(MAX_LEN)) u_walker (
        .clk       (clk),
        .rst       (rst),
        .kick      (kick),
        .tx_ptr    (tx_ptr),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .out_ready (out_ready),
        .ptr_load  (ptr_load),
        .ptr_next  (ptr_next),
        .pkt_inc   (pkt_inc),
        .done_set  (done_set)
    );

endmodule

// File: tb/test_txdesc_walker.sv
module test_txdesc_walker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        tx_irq;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        out_valid, out_last, out_ready;
    logic [7:0]  out_data;

    always #10 clk = ~clk;

    // bench-side memory and stream sink
    logic [15:0] mem [0:4095];
    logic        host_wr = 1'b0;
    logic [11:0] host_a = '0;
    logic [15:0] host_d = '0;
    logic        slow = 1'b0, stall = 1'b0, ph = 1'b0;
    logic [7:0]  cap [0:4095];
    int          cap_n = 0, last_n = 0, last_idx = -1, mem_writes = 0;
    int          watch_hits = 0, arm_at = -1;
    logic [31:0] watch_addr = 32'hFFFF_FFFF;
    int          nchecks = 0, nfails = 0;

    always @(negedge clk) ph <= ~ph;
    assign mem_ack   = mem_req && (!slow || ph);
    assign out_ready = !stall || ph;
    assign mem_rdata = mem[mem_addr[12:1]];

    always @(posedge clk) begin
        if (host_wr) mem[host_a] <= host_d;
        if (mem_req && mem_ack && mem_we) begin
            mem[mem_addr[12:1]] <= mem_wdata;
            mem_writes <= mem_writes + 1;
        end
        if (mem_req && mem_ack && !mem_we && mem_addr == watch_addr) begin
            watch_hits <= watch_hits + 1;
            if (watch_hits == arm_at) mem[mem_addr[12:1]] <= mem[mem_addr[12:1]] | 16'h8000;
        end
        if (out_valid && out_ready) begin
            cap[cap_n] <= out_data;
            cap_n <= cap_n + 1;
            if (out_last) begin
                last_n   <= last_n + 1;
                last_idx <= cap_n;
            end
        end
    end

    txdesc_walker i_txdesc_walker (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_irq(tx_irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready)
    );

    localparam logic [2:0] A_CTL = 3'd0, A_CMD = 3'd1, A_PLO = 3'd2,
                           A_PHI = 3'd3, A_CNT = 3'd4, A_ISR = 3'd5;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nfails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic mem_put(input int byte_addr, input logic [15:0] d);
        host_a = byte_addr[12:1];
        host_d = d;
        host_wr = 1'b1;
        @(posedge clk);
        #1 host_wr = 1'b0;
    endtask

    task automatic put_desc(input int a, input logic [15:0] st, input logic [15:0] len,
                            input int bp, input int nx);
        mem_put(a,      st);
        mem_put(a + 2,  len);
        mem_put(a + 4,  bp[15:0]);
        mem_put(a + 6,  bp[31:16]);
        mem_put(a + 8,  nx[15:0]);
        mem_put(a + 10, nx[31:16]);
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'(seed + k * 7);
    endfunction

    task automatic fill_buf(input int a, input int nbytes, input int seed);
        for (int i = 0; i < (nbytes + 1) / 2; i++)
            mem_put(a + 2 * i, {pat(seed, 2 * i + 1), pat(seed, 2 * i)});
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_ptr(input int p);
        reg_write(A_PLO, p[15:0]);
        reg_write(A_PHI, p[31:16]);
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 8) begin
            @(negedge clk);
            if (!mem_req && !out_valid) quiet++; else quiet = 0;
        end
    endtask

    task automatic check_bytes(input int start, input int n, input int seed, input string tag);
        int bad = 0;
        int first_bad = -1;
        for (int i = 0; i < n; i++)
            if (cap[start + i] !== pat(seed, i)) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        check(bad == 0, tag, first_bad < 0 ? 0 : int'(cap[start + first_bad]),
              first_bad < 0 ? 0 : int'(pat(seed, first_bad)));
    endtask

    task automatic test_reset();
        logic [15:0] d;
        check(tx_irq == 1'b0, "R1 irq after reset", int'(tx_irq), 0);
        check(!mem_req && !out_valid, "R1 idle ports", int'({mem_req, out_valid}), 0);
        for (int a = 0; a < 6; a++) begin
            reg_read(3'(a), d);
            check(d == 16'h0, $sformatf("R1 register %0d reset value", a), int'(d), 0);
        end
    endtask

    task automatic test_single_cmd();
        logic [15:0] d;
        int c0 = cap_n;
        int l0 = last_n;
        put_desc(32'h100, 16'h8123, 16'd5, 32'h400, 32'h120);
        put_desc(32'h120, 16'h0000, 16'd9, 32'h500, 32'h140);
        fill_buf(32'h400, 5, 3);
        set_ptr(32'h100);
        reg_write(A_CMD, 16'h00A5);
        wait_idle();
        check(cap_n - c0 == 5, "R4 odd frame byte count", cap_n - c0, 5);
        check_bytes(c0, 5, 3, "R4 byte order low-first");
        check(last_n - l0 == 1 && last_idx == c0 + 4, "R4 last on final byte", last_idx, c0 + 4);
        check(mem[12'h080] == 16'h0123, "R6 status write-back", int'(mem[12'h080]), 16'h0123);
        reg_read(A_PLO, d);
        check(d == 16'h0120, "R6 pointer low advanced", int'(d), 16'h0120);
        reg_read(A_PHI, d);
        check(d == 16'h0000, "R6 pointer high", int'(d), 0);
        reg_read(A_CMD, d);
        check(d == 16'h00A4, "R2 command bit0 reads zero", int'(d), 16'h00A4);
        check(tx_irq == 1'b1, "R8 irq after productive walk", int'(tx_irq), 1);
        reg_read(A_CNT, d);
        check(d == 16'd1, "R7 one frame counted", int'(d), 1);
        reg_read(A_CNT, d);
        check(d == 16'd0, "R7 counter cleared by read", int'(d), 0);
        reg_read(A_ISR, d);
        check(d == 16'h0010, "R8 status bit4", int'(d), 16'h0010);
        reg_read(A_ISR, d);
        check(d == 16'h0000 && tx_irq == 1'b0, "R8 status cleared by read", int'(d), 0);
    endtask

    task automatic test_chain_ctl();
        logic [15:0] d;
        int c0 = cap_n;
        int l0 = last_n;
        put_desc(32'h200, 16'h8000, 16'd4, 32'h800, 32'h220);
        put_desc(32'h220, 16'h8000, 16'd1, 32'h900, 32'h240);
        put_desc(32'h240, 16'h8000, 16'd6, 32'hA00, 32'h260);
        put_desc(32'h260, 16'h0000, 16'd2, 32'hB00, 32'h280);
        fill_buf(32'h800, 4, 10);
        fill_buf(32'h900, 1, 50);
        fill_buf(32'hA00, 6, 90);
        set_ptr(32'h200);
        slow = 1'b1; stall = 1'b1;
        reg_write(A_CTL, 16'h1000);
        wait_idle();
        slow = 1'b0; stall = 1'b0;
        check(cap_n - c0 == 11, "R3 R10 chain total bytes", cap_n - c0, 11);
        check_bytes(c0, 4, 10, "R4 chain frame 1");
        check_bytes(c0 + 4, 1, 50, "R4 chain frame 2");
        check_bytes(c0 + 5, 6, 90, "R4 chain frame 3");
        check(last_n - l0 == 3, "R4 three end markers", last_n - l0, 3);
        reg_read(A_PLO, d);
        check(d == 16'h0260, "R6 pointer at host-owned desc", int'(d), 16'h0260);
        reg_read(A_CNT, d);
        check(d == 16'd3, "R7 three frames counted", int'(d), 3);
        check(tx_irq == 1'b1, "R8 irq after chain", int'(tx_irq), 1);
        reg_read(A_ISR, d);
    endtask

    task automatic test_ctl_level();
        logic [15:0] d;
        int c0 = cap_n;
        put_desc(32'h260, 16'h8000, 16'd2, 32'hB00, 32'h280);
        put_desc(32'h280, 16'h0000, 16'd2, 32'hB00, 32'h2A0);
        fill_buf(32'hB00, 2, 120);
        reg_write(A_CTL, 16'h1001);
        wait_idle();
        check(cap_n == c0, "R3 bit12 held high starts nothing", cap_n - c0, 0);
        reg_read(A_PLO, d);
        check(d == 16'h0260, "R3 pointer unchanged without edge", int'(d), 16'h0260);
        reg_write(A_CTL, 16'h0000);
        reg_write(A_CTL, 16'h1000);
        wait_idle();
        check(cap_n - c0 == 2, "R3 new rising edge sends", cap_n - c0, 2);
        check_bytes(c0, 2, 120, "R3 frame after edge");
        reg_read(A_CNT, d);
        reg_read(A_ISR, d);
    endtask

    task automatic test_none_owned();
        logic [15:0] d;
        int c0 = cap_n;
        int w0 = mem_writes;
        reg_write(A_CMD, 16'h0001);
        wait_idle();
        check(cap_n == c0 && mem_writes == w0, "R4 host-owned head sends nothing",
              mem_writes - w0, 0);
        check(tx_irq == 1'b0, "R8 no irq for empty walk", int'(tx_irq), 0);
        reg_read(A_CNT, d);
        check(d == 16'd0, "R7 no frame counted", int'(d), 0);
        reg_read(A_PLO, d);
        check(d == 16'h0280, "R4 pointer stays on host-owned desc", int'(d), 16'h0280);
    endtask

    task automatic test_cap_and_zero();
        logic [15:0] d;
        int c0 = cap_n;
        int l0 = last_n;
        put_desc(32'h300, 16'h8000, 16'd2100, 32'h1000, 32'h320);
        put_desc(32'h320, 16'hC007, 16'd0, 32'h1C00, 32'h340);
        put_desc(32'h340, 16'h0000, 16'd0, 32'h1C00, 32'h360);
        fill_buf(32'h1000, 2100, 33);
        set_ptr(32'h300);
        reg_write(A_CMD, 16'h0001);
        wait_idle();
        check(cap_n - c0 == 2000, "R5 length capped", cap_n - c0, 2000);
        check_bytes(c0, 2000, 33, "R5 capped frame content");
        check(last_n - l0 == 1 && last_idx == c0 + 1999, "R5 end marker at cap", last_idx, c0 + 1999);
        check(mem[12'h190] == 16'h4007, "R5 R6 zero-length desc returned", int'(mem[12'h190]), 16'h4007);
        reg_read(A_PLO, d);
        check(d == 16'h0340, "R5 pointer past zero-length desc", int'(d), 16'h0340);
        reg_write(A_CNT, 16'h1234);
        reg_read(A_CNT, d);
        check(d == 16'd2, "R7 counter ignores writes", int'(d), 2);
        reg_read(A_ISR, d);
    endtask

    task automatic test_pending_kick();
        logic [15:0] d;
        int c0 = cap_n;
        int h0 = watch_hits;
        put_desc(32'h600, 16'h8000, 16'd40, 32'h1900, 32'h620);
        put_desc(32'h620, 16'h0000, 16'd3, 32'h1A00, 32'h640);
        put_desc(32'h640, 16'h0000, 16'd0, 32'h1A00, 32'h660);
        fill_buf(32'h1900, 40, 77);
        fill_buf(32'h1A00, 3, 200);
        set_ptr(32'h600);
        watch_addr = 32'h620;
        arm_at = watch_hits;
        stall = 1'b1;
        reg_write(A_CMD, 16'h0001);
        while (cap_n - c0 < 4) @(negedge clk);
        reg_write(A_CMD, 16'h0001);
        wait_idle();
        stall = 1'b0;
        check(cap_n - c0 == 43, "R9 extra pass sends late frame", cap_n - c0, 43);
        check_bytes(c0 + 40, 3, 200, "R9 late frame content");
        check(watch_hits - h0 == 2, "R9 descriptor visited by two walks", watch_hits - h0, 2);
        reg_read(A_CNT, d);
        check(d == 16'd2, "R9 R7 two frames counted", int'(d), 2);
        reg_read(A_PLO, d);
        check(d == 16'h0640, "R9 pointer after extra pass", int'(d), 16'h0640);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nchecks++;
        nfails++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        test_reset();
        test_single_cmd();
        test_chain_ctl();
        test_ctl_level();
        test_none_owned();
        test_cap_and_zero();
        test_pending_kick();
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
        $finish;
    end

endmodule